// File: doc/BRIEF.md
# Atomic Test-and-Set Lock Bank

This block holds a small set of one-bit lock flags that several requesters share through one arbitrated access point. A flag at 0 marks a free lock and a flag at 1 marks a held lock. Each requester can ask for one of three operations on a chosen flag. A test-and-set returns the flag's old value and leaves the flag at 1, as a single indivisible step. A plain read returns the value and leaves the flag unchanged. A release writes 0 without testing the flag first. A requester that sees 0 come back from a test-and-set now owns that lock. A requester that sees 1 has lost and may try again.

Requests use a valid/ready handshake. At most one requester is served in any cycle. A round-robin arbiter picks it, so a requester that spins on a busy lock cannot shut the others out. A request is taken on the rising edge where its valid and ready are both high. Ready is back-pressure: a requester that is not granted must hold valid, opcode and index steady until it sees ready. The response comes back on that requester's own response pins exactly one cycle after the grant. The response has no back-pressure; the requester must accept it in that cycle.

Top module: `tas_lock_bank`

## Requirements
- R1: After reset every flag reads 0, and no ready or response pin is high until a request arrives.
- R2: A test-and-set (opcode 2'b01) on a free lock returns 0 and leaves that lock held, so a later read returns 1.
- R3: A test-and-set on a held lock returns 1 and leaves the lock held.
- R4: A release (opcode 2'b10) returns the old flag value and leaves the flag at 0. This holds when the lock was already free.
- R5: A read (opcode 2'b00) returns the flag value and does not change it.
- R6: In any cycle at most one ready pin is high. It is high only for a requester whose valid is high, and some ready is high whenever any valid is high.
- R7: After requester g is served, the search for the next winner starts at g+1 and wraps. Requester 0 has first pick after reset. A requester that keeps valid high waits fewer than N cycles.
- R8: A requester's response valid is high exactly one cycle after its request was taken, and at no other time. The prior value appears on the same requester's prior pin in that cycle.
- R9: Opcode 2'b11 behaves as a read: it returns the flag and leaves it unchanged.
- R10: An operation touches only the flag it selects (lock index = requester's AW-bit slice of req_idx). The other flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NUM_REQ | Per-requester request valid |
| req_ready | output | NUM_REQ | Per-requester grant; the request is taken when valid and ready are both high |
| req_op | input | 2*NUM_REQ | Opcode of requester i in bits [2i+1:2i] |
| req_idx | input | NUM_REQ*LOCK_AW | Lock index of requester i in bits [LOCK_AW*i +: LOCK_AW] |
| rsp_valid | output | NUM_REQ | Per-requester response valid, one cycle after the grant |
| rsp_prior | output | NUM_REQ | Per-requester flag value seen before the operation |

## Verification
The assertions assume that every requester holds valid and its payload steady until it sees ready. They also assume the lock index stays inside the bank. The fairness check, which bounds each requester's wait to fewer than N cycles, depends on this holding. The bench drives requests at the falling edge and lowers a requester's valid only in the cycle after its grant. It keeps every index within the configured width, so the stimulus stays inside these assumptions. Contention bursts on a single lock show that exactly one test-and-set can win and that service follows the rotating order.

// File: rtl/tas_lock_pkg.sv
package tas_lock_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_TAS   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_ALT   = 2'b11
  } lock_op_e;

  // New flag value after an operation; OP_ALT acts like a read (R9)
  function automatic logic flag_after(lock_op_e op, logic cur);
    case (op)
      OP_TAS:   return 1'b1;
      OP_CLEAR: return 1'b0;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/tas_rr_arb.sv
module tas_rr_arb #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [PW-1:0] gnt_id,
  output logic          gnt_any
);

  logic [PW-1:0] ptr;
  logic [PW:0]   cand;

  // First requester at or after ptr, wrapping
  always_comb begin
    gnt_id  = '0;
    gnt_any = 1'b0;
    cand    = '0;
    for (int k = 0; k < N; k++) begin
      cand = {1'b0, ptr} + (PW+1)'(k);
      if (cand >= (PW+1)'(N)) cand = cand - (PW+1)'(N);
      if (!gnt_any && req[cand[PW-1:0]]) begin
        gnt_any = 1'b1;
        gnt_id  = cand[PW-1:0];
      end
    end
    gnt = gnt_any ? (N'(1) << gnt_id) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (gnt_any) begin
      ptr <= (gnt_id == PW'(N-1)) ? '0 : gnt_id + 1'b1;
    end
  end

endmodule

// File: rtl/tas_flag_bank.sv
module tas_flag_bank
  import tas_lock_pkg::*;
#(
  parameter int AW = 3,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_en,
  input  lock_op_e      op,
  input  logic [AW-1:0] idx,
  output logic          prior
);

  logic [DEPTH-1:0] flags;

  assign prior = flags[idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[g] <= 1'b0;
      end else if (op_en && idx == AW'(g)) begin
        flags[g] <= flag_after(op, flags[g]);
      end
    end
  end

endmodule

// File: rtl/tas_rsp_reg.sv
module tas_rsp_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] gnt,
  input  logic         prior_in,
  output logic [N-1:0] rsp_valid,
  output logic [N-1:0] rsp_prior
);

  for (genvar g = 0; g < N; g++) begin : g_rsp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsp_valid[g] <= 1'b0;
        rsp_prior[g] <= 1'b0;
      end else begin
        rsp_valid[g] <= gnt[g];
        rsp_prior[g] <= gnt[g] & prior_in;
      end
    end
  end

endmodule

// File: rtl/tas_lock_bank.sv
module tas_lock_bank
  import tas_lock_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int LOCK_AW = 3,
  localparam int PW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REQ-1:0]         req_valid,
  output logic [NUM_REQ-1:0]         req_ready,
  input  logic [2*NUM_REQ-1:0]       req_op,
  input  logic [NUM_REQ*LOCK_AW-1:0] req_idx,
  output logic [NUM_REQ-1:0]         rsp_valid,
  output logic [NUM_REQ-1:0]         rsp_prior
);

  logic [PW-1:0]      win_id;
  logic               win_any;
  lock_op_e           sel_op;
  logic [LOCK_AW-1:0] sel_idx;
  logic               sel_prior;

  tas_rr_arb #(.N(NUM_REQ)) arb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_valid),
    .gnt     (req_ready),
    .gnt_id  (win_id),
    .gnt_any (win_any)
  );

  assign sel_op  = lock_op_e'(req_op[win_id*2 +: 2]);
  assign sel_idx = req_idx[win_id*LOCK_AW +: LOCK_AW];

  tas_flag_bank #(.AW(LOCK_AW)) bank_i (
    .clk   (clk),
    .rst_n (rst_n),
    .op_en (win_any),
    .op    (sel_op),
    .idx   (sel_idx),
    .prior (sel_prior)
  );

  tas_rsp_reg #(.N(NUM_REQ)) rsp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt       (req_ready),
    .prior_in  (sel_prior),
    .rsp_valid (rsp_valid),
    .rsp_prior (rsp_prior)
  );

endmodule

// File: rtl/tas_lock_bank_chk.sv
module tas_lock_bank_chk #(
  parameter int NUM_REQ = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] req_valid,
  input logic [NUM_REQ-1:0] req_ready,
  input logic [NUM_REQ-1:0] rsp_valid
);

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  // R6
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // R6
  no_idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |-> (|req_ready));

  // R8
  rsp_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_valid == $past(req_valid & req_ready));

  // R7: bounded wait per requester, counted rather than unrolled
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_wait
    int unsigned wait_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_cnt <= 0;
      else if (req_valid[g] && !req_ready[g]) begin
        if (wait_cnt < NUM_REQ) wait_cnt <= wait_cnt + 1;
      end else wait_cnt <= 0;
    end
    // R7
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt < NUM_REQ);
  end

endmodule

bind tas_lock_bank tas_lock_bank_chk #(.NUM_REQ(NUM_REQ)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/tas_lock_bank_tb_top.sv
`timescale 1ns/1ps
module tas_lock_bank_tb_top;

  localparam int N  = 4;
  localparam int AW = 3;
  localparam int L  = 1 << AW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   req_valid = '0;
  logic [N-1:0]   req_ready;
  logic [2*N-1:0] req_op = '0;
  logic [N*AW-1:0] req_idx = '0;
  logic [N-1:0]   rsp_valid;
  logic [N-1:0]   rsp_prior;

  int checks = 0;
  int errors = 0;

  // model state built from the requirements
  logic [L-1:0] m_flags = '0;
  int           m_ptr = 0;
  logic [N-1:0] pend_gnt = '0;

  int    q_req[$];
  bit    q_prior[$];
  string q_tag[$];

  always #4 clk = ~clk;

  tas_lock_bank #(.NUM_REQ(N), .LOCK_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_idx(req_idx),
    .rsp_valid(rsp_valid), .rsp_prior(rsp_prior)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: timing of responses (R8) and scoreboard of prior values
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_valid != 0 || pend_gnt != 0)
          chk(rsp_valid == pend_gnt, "R8", int'(rsp_valid), int'(pend_gnt));
        pend_gnt = '0;
        for (int i = 0; i < N; i++) begin
          if (rsp_valid[i]) begin
            if (q_req.size() == 0) begin
              chk(1'b0, "R8 unexpected response", i, -1);
            end else begin
              int    er;
              bit    ep;
              string et;
              er = q_req.pop_front();
              ep = q_prior.pop_front();
              et = q_tag.pop_front();
              chk(er == i, et, i, er);
              chk(rsp_prior[i] == ep, et, int'(rsp_prior[i]), int'(ep));
            end
          end
        end
      end
    end
  end

  // driver: masked requesters issue the same op; expected order is round-robin (R7)
  task automatic contend(input logic [N-1:0] mask, input logic [1:0] op,
                         input logic [AW-1:0] idx, input string tag);
    logic [N-1:0] pend;
    pend = mask;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (pend[i]) begin
        req_valid[i] = 1'b1;
        req_op[i*2 +: 2] = op;
        req_idx[i*AW +: AW] = idx;
      end
    end
    while (pend != 0) begin
      int w;
      w = -1;
      #1;
      for (int k = 0; k < N; k++) begin
        int p;
        p = (m_ptr + k) % N;
        if (w < 0 && pend[p]) w = p;
      end
      chk(req_ready == (N'(1) << w), "R7 winner", int'(req_ready), 1 << w);
      q_req.push_back(w);
      q_prior.push_back(m_flags[idx]);
      q_tag.push_back(tag);
      pend_gnt = N'(1) << w;
      if (op == 2'b01) m_flags[idx] = 1'b1;
      else if (op == 2'b10) m_flags[idx] = 1'b0;
      m_ptr = (w + 1) % N;
      @(negedge clk);
      req_valid[w] = 1'b0;
      pend[w] = 1'b0;
    end
  endtask

  task automatic one(input int r, input logic [1:0] op, input logic [AW-1:0] idx,
                     input string tag);
    contend(N'(1) << r, op, idx, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(req_ready == 0, "R1 ready", int'(req_ready), 0);
    chk(rsp_valid == 0, "R1 rsp", int'(rsp_valid), 0);
    for (int j = 0; j < L; j++) one(j % N, 2'b00, AW'(j), "R1 flag clear");

    one(1, 2'b01, 3'd2, "R2 tas free");
    one(3, 2'b00, 3'd2, "R2 held after tas");
    one(0, 2'b01, 3'd2, "R3 tas held");
    one(2, 2'b00, 3'd2, "R3 still held");
    one(2, 2'b00, 3'd5, "R10 other lock");
    one(1, 2'b00, 3'd2, "R5 read again");
    one(0, 2'b11, 3'd2, "R9 alt op");
    one(3, 2'b00, 3'd2, "R9 unchanged");
    one(2, 2'b10, 3'd2, "R4 release held");
    one(0, 2'b00, 3'd2, "R4 after release");
    one(1, 2'b10, 3'd2, "R4 release free");
    one(3, 2'b00, 3'd2, "R4 stays free");

    // R6/R2/R3: all contend for lock 6, exactly one sees 0
    contend(4'b1111, 2'b01, 3'd6, "R6 tas race");
    contend(4'b1010, 2'b00, 3'd6, "R7 reads");
    contend(4'b0111, 2'b10, 3'd6, "R7 releases");
    contend(4'b1101, 2'b01, 3'd7, "R6 second race");
    for (int j = 0; j < L; j++) one(j % N, 2'b00, AW'(j), "R10 final map");

    repeat (3) @(negedge clk);
    chk(q_req.size() == 0, "R8 drained", q_req.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule